// File: doc/BRIEF.md
# Reference-Gated Data Rate Meter

This block measures how fast a recovered data clock runs compared with a reference clock. It opens a counting window that lasts a power-of-two number of reference cycles and counts the data-clock rising edges inside that window. The 23-bit count comes back through a byte-wide register port. The window length grows with a 2-bit reference-band code. Because of this, the count always equals the data rate times 2^(BASE+band) divided by the reference frequency, where BASE defaults to 14.

Software writes the band code and a level-sensitive enable bit into the control register. It then writes the start bit as 1 and then as 0. After that it polls the done bit and reads three result bytes. The block spans three clock domains: the register clock, the reference clock and the data clock. The window request, the window itself and the window-closed event each cross between domains through two-flop synchronizers. The count is copied only after it has stopped changing. A loss-of-lock input marks any reading taken while it was high as invalid.

Top module: `rate_meter`

## Requirements
- R1: After reset the control register (address 0) reads 0, so the band is 00 and enable is off. The status register (address 2) reads 0, and all three result bytes (addresses 3 to 5) read 0.
- R2: The result is the number of data_clk rising edges counted during a window of exactly 2^(BASE+band) ref_clk cycles. It saturates at 2^23-1 and does not wrap.
- R3: The result bits [7:0] read at address 3, bits [15:8] at address 4 and bits [22:16] at address 5. Bit 7 of address 5 always reads 0.
- R4: Enable is bit 2 of address 0 and is level sensitive. Repeated measurements run without ever clearing it. While enable is 0, a start sequence launches nothing and done stays 0.
- R5: The start bit is bit 0 of address 1. Writing it to 1 clears done and invalid. A measurement launches only on a later write of 0 to it, so a write of 1 alone starts nothing.
- R6: Done is bit 0 of address 2. It reads 0 from the start until the result bytes hold the finished count, and then it reads 1. All result bytes change together, in that same cycle.
- R7: Invalid is bit 1 of address 2. It is set if loss_of_lock is high while a measurement is running, and it is cleared by the next write of 1 to the start bit.
- R8: A write to address 0 that changes the band during a running measurement aborts that measurement. Done then stays 0 until the next start sequence, and that next start sequence gives a correct count in the new band.
- R9: Address 0 reads back the band (bits [1:0]) and the enable bit (bit 2) that were last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| ref_clk | input | 1 | Reference clock that times the window |
| data_clk | input | 1 | Recovered data clock whose edges are counted |
| loss_of_lock | input | 1 | High when the data clock is not locked |
| wr_en | input | 1 | Write strobe, sampled on clk |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Combinational read data |

## Verification
A register write takes effect at the next clk edge, so readback and the clearing of done are checked one cycle after the write. Done is due about 2^(BASE+band) reference cycles after the 0 write, plus a few synchronizer cycles in the data and register domains. That delay depends on the clock phases, so the monitor polls status every register cycle and allows a bounded number of polls based on the window length. The bench drives data_clk and ref_clk at integer period ratios. With those ratios the count is exactly the ratio times the window length, and the synchronizer delays cancel because they shift both ends of the window equally. Negative checks (enable off, a 1 write alone, an abort) wait for more than two full windows before they read done.

// File: rtl/rate_meter.sv
module rate_meter #(
  parameter int BASE = 14,
  parameter int RW   = 23
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_clk,
  input  logic       data_clk,
  input  logic       loss_of_lock,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam int GW = BASE + 4;
  localparam logic [RW-1:0] CMAX = {RW{1'b1}};

  logic [1:0]    band, run_band;
  logic          en, stb, done, inval, inflight, discard, relaunch, st_tgl;
  logic [RW-1:0] res;
  logic [2:0]    dd_s;
  logic [1:0]    lol_s;
  logic [2:0]    st_s;
  logic          gate;
  logic [GW-1:0] gcnt, glen;
  logic [2:0]    g_s;
  logic [RW-1:0] dcnt;
  logic          dd_tgl;

  wire wr_ctrl  = wr_en && wr_addr == 3'd0;
  wire wr_cmd   = wr_en && wr_addr == 3'd1;
  wire stb_set  = wr_cmd && wr_data[0];
  wire go       = wr_cmd && !wr_data[0] && stb && en;
  wire ack      = dd_s[2] ^ dd_s[1];
  wire band_chg = wr_ctrl && wr_data[1:0] != band && inflight && !ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band <= '0; run_band <= '0; en <= 1'b0; stb <= 1'b0;
      done <= 1'b0; inval <= 1'b0; inflight <= 1'b0; discard <= 1'b0;
      relaunch <= 1'b0; st_tgl <= 1'b0; res <= '0;
      dd_s <= '0; lol_s <= '0;
    end else begin
      dd_s  <= {dd_s[1:0], dd_tgl};
      lol_s <= {lol_s[0], loss_of_lock};
      if (wr_ctrl) {en, band} <= wr_data[2:0];
      if (wr_cmd) stb <= wr_data[0];
      if (lol_s[1] && inflight && !discard) inval <= 1'b1;
      if (ack) begin
        inflight <= 1'b0;
        discard  <= 1'b0;
        if (!discard && !go) begin
          res  <= dcnt;
          done <= 1'b1;
        end
        if (relaunch) begin
          relaunch <= 1'b0;
          inflight <= 1'b1;
          st_tgl   <= ~st_tgl;
          run_band <= band;
        end
      end
      if (stb_set) begin
        done  <= 1'b0;
        inval <= 1'b0;
      end
      if (go) begin
        if (inflight && !ack) begin
          relaunch <= 1'b1;
          discard  <= 1'b1;
        end else begin
          inflight <= 1'b1;
          st_tgl   <= ~st_tgl;
          run_band <= band;
        end
      end
      if (band_chg) begin
        discard  <= 1'b1;
        relaunch <= 1'b0;
      end
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      st_s <= '0; gate <= 1'b0; gcnt <= '0; glen <= '0;
    end else begin
      st_s <= {st_s[1:0], st_tgl};
      if (st_s[2] ^ st_s[1]) begin
        gate <= 1'b1;
        gcnt <= '0;
        glen <= GW'(1) << (BASE + int'(run_band));
      end else if (gate) begin
        gcnt <= gcnt + 1'b1;
        if (gcnt == glen - 1'b1) gate <= 1'b0;
      end
    end
  end

  always_ff @(posedge data_clk or negedge rst_n) begin
    if (!rst_n) begin
      g_s <= '0; dcnt <= '0; dd_tgl <= 1'b0;
    end else begin
      g_s <= {g_s[1:0], gate};
      if (g_s[1] && !g_s[2]) dcnt <= RW'(1);
      else if (g_s[1] && dcnt != CMAX) dcnt <= dcnt + 1'b1;
      if (!g_s[1] && g_s[2]) dd_tgl <= ~dd_tgl;
    end
  end

  logic [23:0] res_pad;
  assign res_pad = {{(24-RW){1'b0}}, res};

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = {5'b0, en, band};
      3'd1:    rd_data = {7'b0, stb};
      3'd2:    rd_data = {6'b0, inval, done};
      3'd3:    rd_data = res_pad[7:0];
      3'd4:    rd_data = res_pad[15:8];
      3'd5:    rd_data = res_pad[23:16];
      default: rd_data = 8'h00;
    endcase
  end

  AST_STB_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_set |=> !done); // R5
  AST_DONE_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(ack)); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> $stable(res)); // R6
  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    inflight |-> !done); // R6
  AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    band_chg |=> !done); // R8
  AST_NO_WRAP: assert property (@(posedge data_clk) disable iff (!rst_n)
    (g_s[1] && g_s[2] && dcnt == CMAX) |=> dcnt == CMAX); // R2
endmodule

// File: tb/rate_meter_test.sv
module rate_meter_test;
  localparam int BASE = 6;

  logic clk = 1'b0, ref_clk = 1'b0, data_clk = 1'b0;
  logic rst_n = 1'b0, loss_of_lock = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  int dhalf = 4;
  int ratio = 5;
  int tests = 0, fails = 0;
  logic [23:0] exp_q[$];
  bit mon_busy = 0;

  always #10 clk = ~clk;
  always #20 ref_clk = ~ref_clk;
  initial begin
    #1;
    forever #(dhalf) data_clk = ~data_clk;
  end

  rate_meter #(.BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .data_clk(data_clk),
    .loss_of_lock(loss_of_lock), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic measure(input int band, input bit with_lol);
    wr(3'd0, 8'(4 + band));
    wr(3'd1, 8'h01);
    wr(3'd1, 8'h00);
    exp_q.push_back({with_lol, 23'(ratio << (BASE + band))});
    if (with_lol) begin
      repeat (30) @(negedge clk);
      loss_of_lock = 1'b1;
      repeat (5) @(negedge clk);
      loss_of_lock = 1'b0;
    end
    while (exp_q.size() != 0 || mon_busy) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    logic [7:0] s, b0, b1, b2;
    logic [23:0] item;
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        mon_busy = 1;
        item = exp_q[0];
        rd(3'd2, s);
        check("R6 done low while running", int'(s[0]), 0);
        for (int n = 0; n < 4000 && !s[0]; n++) rd(3'd2, s);
        check("R6 done reached", int'(s[0]), 1);
        rd(3'd3, b0); rd(3'd4, b1); rd(3'd5, b2);
        check("R2 count", int'({b2[6:0], b1, b0}), int'(item[22:0]));
        check("R3 top bit zero", int'(b2[7]), 0);
        check("R7 invalid flag", int'(s[1]), int'(item[23]));
        void'(exp_q.pop_front());
        mon_busy = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R1 reset value", int'(d), 0);
    end
    wr(3'd0, 8'h04);
    rd(3'd0, d);
    check("R9 ctrl readback", int'(d), 4);

    measure(0, 0);          // 320 = 0x000140
    rd(3'd4, d);
    check("R3 middle byte", int'(d), 8'h01);
    rd(3'd3, d);
    check("R3 low byte", int'(d), 8'h40);
    measure(1, 0);          // R4 enable stays set across runs
    dhalf = 5; ratio = 4;
    measure(3, 0);
    measure(2, 1);          // R7 lol during window
    measure(0, 0);          // R7 cleared by new start

    wr(3'd0, 8'h00);
    wr(3'd1, 8'h01);
    wr(3'd1, 8'h00);
    repeat (1000) @(negedge clk);
    rd(3'd2, d);
    check("R4 disabled no done", int'(d[0]), 0);
    rd(3'd3, d);
    check("R6 result unchanged", int'(d), 256 & 8'hff);
    rd(3'd4, d);
    check("R6 result unchanged hi", int'(d), 1);

    wr(3'd0, 8'h04);
    wr(3'd1, 8'h01);
    repeat (600) @(negedge clk);
    rd(3'd2, d);
    check("R5 one alone no start", int'(d[0]), 0);
    wr(3'd1, 8'h00);
    exp_q.push_back({1'b0, 23'(ratio << BASE)});
    while (exp_q.size() != 0 || mon_busy) @(negedge clk);

    wr(3'd0, 8'h05);
    wr(3'd1, 8'h01);
    wr(3'd1, 8'h00);
    repeat (20) @(negedge clk);
    wr(3'd0, 8'h06);
    repeat (2000) @(negedge clk);
    rd(3'd2, d);
    check("R8 aborted stays not done", int'(d[0]), 0);
    rd(3'd0, d);
    check("R9 ctrl readback", int'(d), 6);
    wr(3'd1, 8'h01);
    wr(3'd1, 8'h00);
    exp_q.push_back({1'b0, 23'(ratio << (BASE + 2))});
    while (exp_q.size() != 0 || mon_busy) @(negedge clk);
    check("R8 restart after abort", int'(exp_q.size()), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule